// File: doc/BRIEF.md
# Raster Dot and Scanline Timer

This block produces the frame timing for a tile-based video processor. A dot counter runs across each line and a scanline counter runs down the frame. A small line-region state machine turns those counts into three region decodes: visible lines, blanking lines and the single preparation line at the end of the frame. The block also decodes the active pixel window and gives the pixel column index for the pixel pipeline.

The block also holds the vertical-blank status bit. That bit is set at a fixed point inside blanking. It is cleared either at a fixed point on the preparation line, or when the host reads the status register. The interrupt line to the host is the status bit gated by an enable bit from the control register. At the preparation-line clear point, a one-cycle strobe tells neighbouring logic to clear its sprite status bits.

The line-region machine has four states:
- `RG_VISIBLE`: picture lines.
- `RG_POSTLINE`: the single idle line right after the picture.
- `RG_VBLANK`: the rest of blanking.
- `RG_PRERENDER`: the last line of the frame.

It moves only at a line end:
- `RG_VISIBLE` to `RG_POSTLINE` when the last picture line ends.
- `RG_POSTLINE` to `RG_VBLANK` unconditionally.
- `RG_VBLANK` to `RG_PRERENDER` when the second-to-last line ends.
- `RG_PRERENDER` to `RG_VISIBLE`, which wraps the frame.

The status machine has two states, `FL_CLEAR` and `FL_SET`:
- `FL_CLEAR` to `FL_SET` on the set event, when no read is present.
- `FL_SET` to `FL_CLEAR` on a read or on the preparation-line clear event.

Top module: `raster_timer`

## Requirements
- R1: `dot_num` counts 0 to 340 on successive clocks. After 340 it returns to 0, and `line_num` advances on that same edge.
- R2: `line_num` counts 0 to 261. After dot 340 of line 261, both counters return to 0.
- R3: Exactly one of the three region outputs is high at a time:
  - `in_visible` on lines 0 to 239.
  - `in_blank` on lines 240 to 260.
  - `in_prerender` on line 261.
- R4: `pix_active` is high only on dots 1 to 256 of visible lines, and then `pix_x` equals `dot_num` minus 1. Otherwise `pix_x` is 0.
- R5: `vblank` first reads 1 in the cycle where `line_num` is 241 and `dot_num` is 1. It is still 0 at dot 0 of that line and on line 240.
- R6: If still set, `vblank` reads 0 from the cycle at line 261, dot 1. It still reads 1 at dot 0 of that line.
- R7: A cycle with `stat_rd` high makes `vblank` read 0 from the next cycle. It stays 0 until the next set point.
- R8: If `stat_rd` is high in the cycle at line 241, dot 0, `vblank` stays 0 at dot 1 and for the rest of that blanking period.
- R9: `irq` equals `vblank` AND `irq_en` in the same cycle. A status read therefore drops it.
- R10: `sprite_stat_clr` is high only in the cycle at line 261, dot 1.
- R11: During and right after reset: `dot_num` = 0, `line_num` = 0, `in_visible` = 1, `vblank` = 0, `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_rd | input | 1 | One-cycle strobe for a host read of the status register |
| irq_en | input | 1 | Interrupt-enable bit from the control register |
| dot_num | output | 9 | Dot position within the line |
| line_num | output | 9 | Scanline number within the frame |
| in_visible | output | 1 | Current line is a picture line |
| in_blank | output | 1 | Current line is a blanking line |
| in_prerender | output | 1 | Current line is the preparation line |
| pix_active | output | 1 | A pixel is output in this cycle |
| pix_x | output | 8 | Pixel column index (dot minus 1) |
| vblank | output | 1 | Vertical-blank status bit |
| irq | output | 1 | Interrupt request to the host |
| sprite_stat_clr | output | 1 | Strobe that clears the sprite status bits |

## Verification
The embedded properties check every cycle that:
- the dot counter steps and wraps;
- the line counter advances only at line ends and wraps after the last line;
- the region state agrees with the line number;
- a status read, a set event or a clear event moves the status bit to the right value on the next edge;
- the sprite-clear strobe occurs only on the preparation line.

Only the directed scenarios can show the absolute positions:
- that the bit first appears exactly at dot 1 of line 241;
- that a read landing on the set cycle suppresses the whole blanking period, shown on a shortened-frame instance;
- how the interrupt follows the enable bit;
- where the pixel column index starts and stops.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic [1:0] {
        RG_VISIBLE   = 2'd0,
        RG_POSTLINE  = 2'd1,
        RG_VBLANK    = 2'd2,
        RG_PRERENDER = 2'd3
    } region_e;

    typedef enum logic {
        FL_CLEAR = 1'b0,
        FL_SET   = 1'b1
    } flag_e;

endpackage

// File: rtl/raster_dot_ctr.sv
module raster_dot_ctr #(
    parameter int DOTS = 341,
    parameter int W    = $clog2(DOTS)
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] dot,
    output logic         line_end
);
    localparam logic [W-1:0] LAST = W'(DOTS - 1);

    always_comb line_end = (dot == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)        dot <= '0;
        else if (line_end) dot <= '0;
        else               dot <= dot + 1'b1;
    end

    // R1: wrap after the last dot
    a_r1_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dot == LAST) |=> (dot == '0));

    // R1: single step otherwise
    a_r1_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dot != LAST) |=> (dot == $past(dot) + 1'b1));

endmodule

// File: rtl/raster_line_fsm.sv
module raster_line_fsm
    import raster_pkg::*;
#(
    parameter int LINES   = 262,
    parameter int VISIBLE = 240,
    parameter int W       = $clog2(LINES)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line_end,
    output logic [W-1:0] line,
    output region_e      region,
    output logic         in_visible,
    output logic         in_blank,
    output logic         in_prerender
);
    localparam logic [W-1:0] LAST_LINE = W'(LINES - 1);
    localparam logic [W-1:0] LAST_PIC  = W'(VISIBLE - 1);
    localparam logic [W-1:0] LAST_VBL  = W'(LINES - 2);
    localparam logic [W-1:0] POST_LINE = W'(VISIBLE);

    region_e region_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line <= '0;
        end else if (line_end) begin
            line <= (line == LAST_LINE) ? '0 : line + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) region <= RG_VISIBLE;
        else        region <= region_d;
    end

    always_comb begin
        region_d = region;
        unique case (region)
            RG_VISIBLE:   if (line_end && line == LAST_PIC) region_d = RG_POSTLINE;
            RG_POSTLINE:  if (line_end)                     region_d = RG_VBLANK;
            RG_VBLANK:    if (line_end && line == LAST_VBL) region_d = RG_PRERENDER;
            RG_PRERENDER: if (line_end)                     region_d = RG_VISIBLE;
            default:                                        region_d = RG_VISIBLE;
        endcase
    end

    always_comb begin
        in_visible   = 1'b0;
        in_blank     = 1'b0;
        in_prerender = 1'b0;
        unique case (region)
            RG_VISIBLE:   in_visible   = 1'b1;
            RG_POSTLINE:  in_blank     = 1'b1;
            RG_VBLANK:    in_blank     = 1'b1;
            RG_PRERENDER: in_prerender = 1'b1;
            default:      in_visible   = 1'b1;
        endcase
    end

    // R2: wrap after the last line
    a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && line == LAST_LINE) |=> (line == '0));

    // R2: line holds within a line
    a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(line));

    // R3: the state register agrees with the line counter
    a_r3_region_vis: assert property (@(posedge clk) disable iff (!rst_n)
        (line <= LAST_PIC) |-> (region == RG_VISIBLE));
    a_r3_region_post: assert property (@(posedge clk) disable iff (!rst_n)
        (line == POST_LINE) |-> (region == RG_POSTLINE));
    a_r3_region_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (line == LAST_LINE) |-> (region == RG_PRERENDER));
    a_r3_region_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({in_visible, in_blank, in_prerender}) == 1);

endmodule

// File: rtl/raster_vblank_flag.sv
module raster_vblank_flag
    import raster_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic rd,
    output logic flag
);
    flag_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: if (set_evt && !rd)  state_d = FL_SET;
            FL_SET:   if (rd || clr_evt)   state_d = FL_CLEAR;
            default:                       state_d = FL_CLEAR;
        endcase
    end

    always_comb flag = (state_q == FL_SET);

    // R5: set event without a read raises the bit
    a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !rd) |=> flag);

    // R7 and R8: a read always leaves the bit clear
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> !flag);

    // R6: preparation-line clear
    a_r6_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> !flag);

    // R5: the bit only rises through a set event
    a_r5_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_evt));

endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VISIBLE_LINES   = 240,
    parameter int PIX_WIDTH       = 256,
    parameter int DOT_W           = $clog2(DOTS_PER_LINE),
    parameter int LINE_W          = $clog2(LINES_PER_FRAME),
    parameter int PIXX_W          = $clog2(PIX_WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              irq_en,
    output logic [DOT_W-1:0]  dot_num,
    output logic [LINE_W-1:0] line_num,
    output logic              in_visible,
    output logic              in_blank,
    output logic              in_prerender,
    output logic              pix_active,
    output logic [PIXX_W-1:0] pix_x,
    output logic              vblank,
    output logic              irq,
    output logic              sprite_stat_clr
);
    localparam logic [LINE_W-1:0] SET_LINE  = LINE_W'(VISIBLE_LINES + 1);
    localparam logic [LINE_W-1:0] PRE_LINE  = LINE_W'(LINES_PER_FRAME - 1);
    localparam logic [DOT_W-1:0]  PIX_FIRST = DOT_W'(1);
    localparam logic [DOT_W-1:0]  PIX_LAST  = DOT_W'(PIX_WIDTH);

    logic             line_end;
    region_e          region;
    logic             set_evt;
    logic             clr_evt;
    logic [DOT_W-1:0] dot_m1;

    raster_dot_ctr #(
        .DOTS (DOTS_PER_LINE),
        .W    (DOT_W)
    ) u_dot (
        .clk      (clk),
        .rst_n    (rst_n),
        .dot      (dot_num),
        .line_end (line_end)
    );

    raster_line_fsm #(
        .LINES   (LINES_PER_FRAME),
        .VISIBLE (VISIBLE_LINES),
        .W       (LINE_W)
    ) u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_end     (line_end),
        .line         (line_num),
        .region       (region),
        .in_visible   (in_visible),
        .in_blank     (in_blank),
        .in_prerender (in_prerender)
    );

    // events fire in the dot-0 cycle so the bit changes as dot 1 begins
    always_comb begin
        set_evt = (region == RG_VBLANK)    && (line_num == SET_LINE) && (dot_num == '0);
        clr_evt = (region == RG_PRERENDER) && (dot_num == '0);
    end

    raster_vblank_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .clr_evt (clr_evt),
        .rd      (stat_rd),
        .flag    (vblank)
    );

    always_comb begin
        dot_m1          = dot_num - 1'b1;
        pix_active      = in_visible && (dot_num >= PIX_FIRST) && (dot_num <= PIX_LAST);
        pix_x           = pix_active ? dot_m1[PIXX_W-1:0] : '0;
        irq             = vblank && irq_en;
        sprite_stat_clr = in_prerender && (dot_num == PIX_FIRST);
    end

    // R10: strobe only on the preparation line, one cycle long
    a_r10_clr_on_pre: assert property (@(posedge clk) disable iff (!rst_n)
        sprite_stat_clr |-> (line_num == PRE_LINE));
    a_r10_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        sprite_stat_clr |=> !sprite_stat_clr);

    // R6: status bit is never set on a picture line after the clear point
    a_r6_clear_in_picture: assert property (@(posedge clk) disable iff (!rst_n)
        (in_visible && $past(in_visible)) |-> !vblank);

endmodule

// File: tb/test_raster_timer.sv
`timescale 1ns/1ps
module test_raster_timer;

    localparam int DPL   = 341;
    localparam int FRAME = 341 * 262;
    localparam int M_DPL = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stat_rd = 1'b0;
    logic irq_en = 1'b0;
    logic m_rd = 1'b0;

    logic [8:0] dot_num;
    logic [8:0] line_num;
    logic       in_visible, in_blank, in_prerender, pix_active;
    logic [7:0] pix_x;
    logic       vblank, irq, sprite_stat_clr;

    logic [4:0] m_dot;
    logic [3:0] m_line;
    logic       m_vis, m_blank, m_pre, m_pix, m_vbl, m_irq, m_sclr;
    logic [3:0] m_px;

    int kcnt = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) kcnt <= 0;
        else        kcnt <= kcnt + 1;
    end

    raster_timer i_raster_timer (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .irq_en(irq_en),
        .dot_num(dot_num), .line_num(line_num), .in_visible(in_visible),
        .in_blank(in_blank), .in_prerender(in_prerender), .pix_active(pix_active),
        .pix_x(pix_x), .vblank(vblank), .irq(irq), .sprite_stat_clr(sprite_stat_clr)
    );

    // shortened frame: 24 dots, 14 lines, 8 picture lines, set line 9
    raster_timer #(
        .DOTS_PER_LINE(24), .LINES_PER_FRAME(14), .VISIBLE_LINES(8), .PIX_WIDTH(16)
    ) i_raster_timer_mini (
        .clk(clk), .rst_n(rst_n), .stat_rd(m_rd), .irq_en(1'b0),
        .dot_num(m_dot), .line_num(m_line), .in_visible(m_vis),
        .in_blank(m_blank), .in_prerender(m_pre), .pix_active(m_pix),
        .pix_x(m_px), .vblank(m_vbl), .irq(m_irq), .sprite_stat_clr(m_sclr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, kcnt);
        end
    endtask

    task automatic goto_cycle(input int t);
        while (kcnt != t) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11", "dot", int'(dot_num), 0);
        check("R11", "line", int'(line_num), 0);
        check("R11", "visible", int'(in_visible), 1);
        check("R11", "vblank", int'(vblank), 0);
        check("R11", "irq", int'(irq), 0);
        check("R4", "pix_active at dot 0", int'(pix_active), 0);
    endtask

    task automatic t_mini_collision();
        goto_cycle(9 * M_DPL);
        check("R8", "mini line at set point", int'(m_line), 9);
        m_rd = 1'b1;
        @(negedge clk);
        m_rd = 1'b0;
        check("R8", "mini dot", int'(m_dot), 1);
        check("R8", "mini vblank after collision", int'(m_vbl), 0);
        goto_cycle(11 * M_DPL + 3);
        check("R8", "mini vblank later in blanking", int'(m_vbl), 0);
        check("R3", "mini in_blank", int'(m_blank), 1);
    endtask

    task automatic t_line_wrap();
        goto_cycle(DPL - 1);
        check("R1", "dot before wrap", int'(dot_num), 340);
        check("R1", "line before wrap", int'(line_num), 0);
        goto_cycle(DPL);
        check("R1", "dot after wrap", int'(dot_num), 0);
        check("R1", "line after wrap", int'(line_num), 1);
    endtask

    task automatic t_pixel_window();
        goto_cycle(DPL + 1);
        check("R4", "active at dot 1", int'(pix_active), 1);
        check("R4", "x at dot 1", int'(pix_x), 0);
        goto_cycle(DPL + 100);
        check("R4", "x at dot 100", int'(pix_x), 99);
        goto_cycle(DPL + 256);
        check("R4", "active at dot 256", int'(pix_active), 1);
        check("R4", "x at dot 256", int'(pix_x), 255);
        goto_cycle(DPL + 257);
        check("R4", "active at dot 257", int'(pix_active), 0);
        check("R4", "x at dot 257", int'(pix_x), 0);
    endtask

    task automatic t_regions();
        goto_cycle(239 * DPL + 5);
        check("R3", "visible line 239", int'(in_visible), 1);
        check("R3", "blank line 239", int'(in_blank), 0);
        goto_cycle(240 * DPL + 5);
        check("R3", "blank line 240", int'(in_blank), 1);
        check("R3", "visible line 240", int'(in_visible), 0);
        check("R4", "no pixel on line 240", int'(pix_active), 0);
        check("R5", "vblank on line 240", int'(vblank), 0);
    endtask

    task automatic t_vblank_set();
        goto_cycle(241 * DPL);
        check("R5", "vblank at 241/0", int'(vblank), 0);
        goto_cycle(241 * DPL + 1);
        check("R5", "vblank at 241/1", int'(vblank), 1);
        check("R9", "irq with enable low", int'(irq), 0);
        irq_en = 1'b1;
        #1;
        check("R9", "irq with enable high", int'(irq), 1);
        goto_cycle(260 * DPL + 340);
        check("R5", "vblank at 260/340", int'(vblank), 1);
        check("R3", "blank at 260", int'(in_blank), 1);
    endtask

    task automatic t_prerender_clear();
        goto_cycle(261 * DPL);
        check("R3", "prerender at 261", int'(in_prerender), 1);
        check("R6", "vblank at 261/0", int'(vblank), 1);
        check("R10", "strobe at 261/0", int'(sprite_stat_clr), 0);
        goto_cycle(261 * DPL + 1);
        check("R6", "vblank at 261/1", int'(vblank), 0);
        check("R9", "irq after clear", int'(irq), 0);
        check("R10", "strobe at 261/1", int'(sprite_stat_clr), 1);
        goto_cycle(261 * DPL + 2);
        check("R10", "strobe at 261/2", int'(sprite_stat_clr), 0);
    endtask

    task automatic t_frame_wrap();
        goto_cycle(FRAME - 1);
        check("R2", "line at frame end", int'(line_num), 261);
        check("R2", "dot at frame end", int'(dot_num), 340);
        goto_cycle(FRAME);
        check("R2", "line after frame wrap", int'(line_num), 0);
        check("R2", "dot after frame wrap", int'(dot_num), 0);
        check("R3", "visible after frame wrap", int'(in_visible), 1);
    endtask

    task automatic t_read_clear();
        goto_cycle(FRAME + 241 * DPL + 1);
        check("R5", "vblank second frame", int'(vblank), 1);
        check("R9", "irq second frame", int'(irq), 1);
        goto_cycle(FRAME + 241 * DPL + 50);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R7", "vblank after read", int'(vblank), 0);
        check("R9", "irq after read", int'(irq), 0);
        goto_cycle(FRAME + 243 * DPL + 7);
        check("R7", "vblank stays clear", int'(vblank), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_mini_collision();
        t_line_wrap();
        t_pixel_window();
        t_regions();
        t_vblank_set();
        t_prerender_clear();
        t_frame_wrap();
        t_read_clear();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected completion", kcnt);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule